// File: doc/BRIEF.md
# Keyed Watchdog Timer with Write Protection

This block is a watchdog counter that sits on a 16-bit register bus. It holds a free-running 8-bit counter that advances on a divided timebase. It also holds a key register used to service the counter, a control register carrying a check field together with disable and prescale bits, and a status word carrying a sticky override bit. Software keeps the system alive by writing the arming key 0x55 and then the firing key 0xAA. That pair clears the counter. If software stops servicing and the counter rolls over from all-ones, the block drives a reset pulse. When the wake input is high, it drives a one-cycle wake pulse instead.

Every register write is gated by a protection flag. One input opens the flag and a different input closes it. A write to the control register must carry the check pattern 3'b101. A write with any other pattern is treated as a fault and fires the reset at once. The check field never reads back as anything but zero. Reading the key location returns the control register.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the control word reads 0x0000, the status word reads 0x0001 (override set), the counter reads 0, the write flag is closed, and neither wd_reset nor wd_wake is high.
- R2: Writes to any register take effect only while the protection flag is open. A pulse on prot_set opens it, and a pulse on prot_clr closes it. When both are high in the same cycle, closing wins.
- R3: The low byte of a key write (word offset 21) is decoded as follows. 0x55 arms the sequence. 0xAA while armed clears the counter, restarts the timebase and disarms. 0xAA while unarmed changes nothing. Any other value disarms.
- R4: A control write (offset 25) whose bits 5:3 equal 3'b101 stores bits 2:0 (prescale) and bit 6 (disable). A control write with any other bits 5:3 leaves the control word unchanged and raises wd_reset on the next clock. The control word reads back as {9'b0, disable, 3'b000, prescale}.
- R5: A read of the key offset returns the same value as a read of the control offset.
- R6: Status bit 0 (offset 18) is the override bit. Writing 1 to it clears it. Writing 0 has no effect. Once cleared it stays 0 until reset.
- R7: A disable value of 1 is stored only while override is 1. Writing disable as 0 always re-enables counting. While disabled, the counter holds its value.
- R8: The counter advances once every BASE_DIV×D clocks. D is 1 for prescale 0 or 1, and 2^(p−1) for prescale p from 2 to 7. After a key clear, wd_reset rises 256×BASE_DIV×D clocks after the clearing write.
- R9: When the counter overflows from 0xFF with wake_en low, wd_reset goes high for exactly RST_LEN clocks. The counter is held at 0 during the pulse and counts up from 0 afterwards. A bad-check fault produces the same RST_LEN-long pulse.
- R10: When the counter overflows with wake_en high, wd_wake is high for exactly one clock, wd_reset stays low, and the counter continues from 0.
- R11: bus_rdata reflects the word at bus_addr one clock later. The counter reads at offset 19 in the low byte. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_set | input | 1 | Opens the register write flag |
| prot_clr | input | 1 | Closes the register write flag (wins over prot_set) |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 5 | Word offset within the 32-word block |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| wake_en | input | 1 | Turns an overflow into a wake pulse instead of a reset |
| wd_reset | output | 1 | Watchdog reset pulse |
| wd_wake | output | 1 | One-cycle wake pulse |

## Verification
The bench targets several corner cases.

- **Unarmed 0xAA write.** A design that clears the counter on this write would read back a small counter where the bench expects growth.
- **Override bit.** A design that lets a zero write touch the override bit would let the watchdog be disabled after lock-down. So would a design that lets a write-one set the bit back.
- **Writes with the flag closed.** A bad-check write must not fire a reset while the flag is closed, and a prot_set arriving together with prot_clr must not open the flag. A design that gets either wrong fires resets or changes registers it should not.
- **Prescale and overflow timing.** The bench measures the overflow distance for several prescale settings, including the largest, and measures the pulse width. An off-by-one divider or a wrong divide decode lands outside the expected window.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'd18;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 5'd19;
  localparam logic [ADDR_W-1:0] OFS_KEY  = 5'd21;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'd25;
  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;
  localparam logic [2:0] CHK_GOOD = 3'b101;
  typedef enum logic {KS_IDLE, KS_ARMED} key_st_e;
endpackage

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq
  import kwdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic [7:0] key_val,
  output logic       armed,
  output logic       kick
);
  key_st_e st_q;

  assign armed = (st_q == KS_ARMED);
  assign kick  = key_wr && (key_val == KEY_FIRE) && armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= KS_IDLE;
    end else if (key_wr) begin
      if (key_val == KEY_ARM) st_q <= KS_ARMED;
      else                    st_q <= KS_IDLE;
    end
  end
endmodule

// File: rtl/kwdt_timebase.sv
module kwdt_timebase #(
  parameter int unsigned BASE_DIV = 512,
  parameter int unsigned SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned BW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam int unsigned PW = (1 << SEL_W) - 2;

  logic [BW-1:0] base_q;
  logic [PW-1:0] psc_q;
  logic [PW-1:0] mask;
  logic          base_end;

  assign base_end = (base_q == BW'(BASE_DIV - 1));

  // bit b of the mask is set when the divide ratio needs it
  always_comb begin
    for (int b = 0; b < PW; b++) mask[b] = (int'(sel) >= b + 2);
  end

  assign tick = run && base_end && ((psc_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      base_q <= '0;
      psc_q  <= '0;
    end else if (run) begin
      base_q <= base_end ? '0 : base_q + 1'b1;
      if (base_end) psc_q <= psc_q + 1'b1;
    end
  end
endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
  parameter int unsigned LEN = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic out
);
  localparam int unsigned LW = $clog2(LEN + 1);
  logic [LW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out    <= 1'b0;
      left_q <= '0;
    end else if (!out) begin
      if (fire) begin
        out    <= 1'b1;
        left_q <= LW'(LEN - 1);
      end
    end else if (left_q == '0) begin
      out <= 1'b0;
    end else begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned BASE_DIV = 512,
  parameter int unsigned RST_LEN  = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prot_set,
  input  logic              prot_clr,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              wake_en,
  output logic              wd_reset,
  output logic              wd_wake
);
  logic             prot_q;
  logic             ovr_q;
  logic             dis_q;
  logic [2:0]       ps_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_ok, key_wr, ctrl_wr, stat_wr, bad_chk;
  logic             key_armed, kick, tick, run, ovf;
  logic [DW-1:0]    ctrl_view;

  assign wr_ok   = bus_we && prot_q;
  assign key_wr  = wr_ok && (bus_addr == OFS_KEY);
  assign ctrl_wr = wr_ok && (bus_addr == OFS_CTRL);
  assign stat_wr = wr_ok && (bus_addr == OFS_STAT);
  assign bad_chk = ctrl_wr && (bus_wdata[5:3] != CHK_GOOD);

  always_ff @(posedge clk) begin
    if (rst)           prot_q <= 1'b0;
    else if (prot_clr) prot_q <= 1'b0;
    else if (prot_set) prot_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q <= 1'b1;
      dis_q <= 1'b0;
      ps_q  <= 3'd0;
    end else begin
      if (stat_wr && bus_wdata[0]) ovr_q <= 1'b0;
      if (ctrl_wr && !bad_chk) begin
        ps_q <= bus_wdata[2:0];
        if (ovr_q || !bus_wdata[6]) dis_q <= bus_wdata[6];
      end
    end
  end

  kwdt_keyseq u_key (
    .clk    (clk),
    .rst    (rst),
    .key_wr (key_wr),
    .key_val(bus_wdata[7:0]),
    .armed  (key_armed),
    .kick   (kick)
  );

  assign run = !dis_q && !wd_reset;

  kwdt_timebase #(.BASE_DIV(BASE_DIV), .SEL_W(3)) u_tb (
    .clk    (clk),
    .rst    (rst),
    .restart(kick || wd_reset),
    .run    (run),
    .sel    (ps_q),
    .tick   (tick)
  );

  assign ovf = run && tick && (&cnt_q) && !kick;

  always_ff @(posedge clk) begin
    if (rst || kick || wd_reset) cnt_q <= '0;
    else if (run && tick)        cnt_q <= cnt_q + 1'b1;
  end

  kwdt_pulse #(.LEN(RST_LEN)) u_rst (
    .clk (clk),
    .rst (rst),
    .fire(bad_chk || (ovf && !wake_en)),
    .out (wd_reset)
  );

  always_ff @(posedge clk) begin
    if (rst) wd_wake <= 1'b0;
    else     wd_wake <= ovf && wake_en;
  end

  assign ctrl_view = {{(DW-7){1'b0}}, dis_q, 3'b000, ps_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      unique case (bus_addr)
        OFS_STAT:          bus_rdata <= {{(DW-1){1'b0}}, ovr_q};
        OFS_CNT:           bus_rdata <= {{(DW-CNT_W){1'b0}}, cnt_q};
        OFS_KEY, OFS_CTRL: bus_rdata <= ctrl_view;
        default:           bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk
  import kwdt_pkg::*;
#(
  parameter int unsigned DW      = 16,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_LEN = 512
) (
  input logic              clk,
  input logic              rst,
  input logic              prot_q,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              wd_reset,
  input logic              ovr_q,
  input logic              key_armed,
  input logic [CNT_W-1:0]  cnt_q
);
  localparam int unsigned RW = $clog2(RST_LEN + 2);
  logic [RW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (wd_reset) run_len <= run_len + 1'b1;
    else          run_len <= '0;
  end

  // R9
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(wd_reset) && !$past(rst)) |-> (run_len == RW'(RST_LEN)));

  // R9
  pulse_max_chk: assert property (@(posedge clk) disable iff (rst)
    wd_reset |-> (run_len < RW'(RST_LEN)));

  // R3
  armed_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (prot_q && bus_we && bus_addr == OFS_KEY && bus_wdata[7:0] == KEY_FIRE && key_armed)
    |=> (cnt_q == '0));

  // R3
  unarmed_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (prot_q && bus_we && bus_addr == OFS_KEY && bus_wdata[7:0] == KEY_FIRE && !key_armed
     && cnt_q != '0 && !(&cnt_q)) |=> (cnt_q != '0));

  // R4
  bad_check_chk: assert property (@(posedge clk) disable iff (rst)
    (prot_q && bus_we && bus_addr == OFS_CTRL && bus_wdata[5:3] != CHK_GOOD && !wd_reset)
    |=> wd_reset);

  // R2
  closed_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!prot_q && bus_we && bus_addr == OFS_STAT) |=> $stable(ovr_q));

  // R6
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !ovr_q |=> !ovr_q);

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1));
endmodule

bind keyed_wdt kwdt_chk #(.DW(DW), .CNT_W(CNT_W), .RST_LEN(RST_LEN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .prot_q   (prot_q),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .wd_reset (wd_reset),
  .ovr_q    (ovr_q),
  .key_armed(key_armed),
  .cnt_q    (cnt_q)
);

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
  localparam int DW = 16;
  localparam int BASE_DIV = 4;
  localparam int RST_LEN = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prot_set = 1'b0, prot_clr = 1'b0, bus_we = 1'b0, wake_en = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic wd_reset, wd_wake;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  keyed_wdt #(.DW(DW), .CNT_W(8), .BASE_DIV(BASE_DIV), .RST_LEN(RST_LEN)) u_dut (
    .clk(clk), .rst(rst), .prot_set(prot_set), .prot_clr(prot_clr),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wake_en(wake_en), .wd_reset(wd_reset), .wd_wake(wd_wake));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int div_of(input int p);
    return (p < 2) ? 1 : (1 << (p - 1));
  endfunction

  function automatic logic [15:0] ctrl_word(input bit dis, input int p, input logic [2:0] c);
    return {9'b0, dis, c, 3'(p)};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic open_flag();
    @(negedge clk); prot_set = 1'b1;
    @(negedge clk); prot_set = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output int v);
    @(negedge clk); bus_addr = a;
    @(negedge clk); v = int'(bus_rdata);
  endtask

  task automatic kick_seq();
    wr(5'd21, 16'h0055);
    wr(5'd21, 16'h00AA);
  endtask

  // counts negedges from the clearing write until wd_reset (or wd_wake) is seen
  task automatic measure(input bit wake, output int n);
    n = 1;
    while (!(wake ? wd_wake : wd_reset) && n < 70000) begin
      @(negedge clk); n++;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int v, v2, n, prev, p;
    bit armed_m, dis_m;
    int ps_m;
    logic [7:0] kv;
    logic [2:0] c;

    void'($urandom(32'd4711));
    do_reset();

    // R1 reset state
    rd(5'd25, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(5'd18, v); chk(v == 1, "R1 status", v, 1);
    rd(5'd19, v); chk(v <= 1, "R1 counter", v, 0);
    chk(!wd_reset && !wd_wake, "R1 outputs", int'(wd_reset), 0);

    // R2 writes while closed
    wr(5'd25, 16'h0000);
    chk(!wd_reset, "R2 closed bad check", int'(wd_reset), 0);
    wr(5'd25, ctrl_word(0, 3, 3'b101));
    rd(5'd25, v); chk(v == 0, "R2 closed ctrl", v, 0);
    wr(5'd18, 16'h0001);
    rd(5'd18, v); chk(v == 1, "R2 closed status", v, 1);
    @(negedge clk); prot_set = 1'b1; prot_clr = 1'b1;
    @(negedge clk); prot_set = 1'b0; prot_clr = 1'b0;
    wr(5'd25, ctrl_word(0, 4, 3'b101));
    rd(5'd25, v); chk(v == 0, "R2 clear wins", v, 0);

    // R11 unmapped offsets
    rd(5'd0, v);  chk(v == 0, "R11 offset 0", v, 0);
    rd(5'd20, v); chk(v == 0, "R11 offset 20", v, 0);

    // R3 random key stream
    open_flag();
    repeat (20) @(negedge clk);
    armed_m = 0;
    for (int i = 0; i < 40; i++) begin
      case ($urandom % 4)
        0, 1: kv = 8'h55;
        2:    kv = 8'hAA;
        default: kv = 8'($urandom);
      endcase
      rd(5'd19, prev);
      wr(5'd21, {8'($urandom), kv});
      rd(5'd19, v);
      if (kv == 8'hAA && armed_m) chk(v <= 1, "R3 armed clear", v, 0);
      else chk(v >= prev, "R3 no clear", v, prev);
      armed_m = (kv == 8'h55);
    end

    // R4 / R5 random control writes (override still set)
    ps_m = 0; dis_m = 0;
    for (int i = 0; i < 12; i++) begin
      p = int'($urandom % 8);
      c = ($urandom % 3 == 0) ? 3'($urandom) : 3'b101;
      kv = 8'($urandom % 2);
      wr(5'd25, ctrl_word(kv[0], p, c));
      if (c == 3'b101) begin
        ps_m = p; dis_m = kv[0];
        chk(!wd_reset, "R4 good check no reset", int'(wd_reset), 0);
      end else begin
        chk(wd_reset, "R4 bad check reset", int'(wd_reset), 1);
        n = 1;
        while (wd_reset) begin @(negedge clk); if (wd_reset) n++; end
        chk(n == RST_LEN, "R9 fault pulse width", n, RST_LEN);
      end
      rd(5'd25, v);
      chk(v == int'(ctrl_word(dis_m, ps_m, 3'b000)), "R4 ctrl readback", v, int'(ctrl_word(dis_m, ps_m, 3'b000)));
      rd(5'd21, v2);
      chk(v2 == v, "R5 key reads ctrl", v2, v);
    end

    // R6 / R7 override
    do_reset(); open_flag();
    wr(5'd18, 16'hFFFE);
    rd(5'd18, v); chk(v == 1, "R6 zero write ignored", v, 1);
    wr(5'd25, ctrl_word(1, 0, 3'b101));
    rd(5'd19, prev);
    repeat (40) @(negedge clk);
    rd(5'd19, v); chk(v == prev, "R7 disabled holds", v, prev);
    wr(5'd25, ctrl_word(0, 0, 3'b101));
    wr(5'd18, 16'h0001);
    rd(5'd18, v); chk(v == 0, "R6 w1c", v, 0);
    wr(5'd18, 16'h0001);
    rd(5'd18, v); chk(v == 0, "R6 sticky", v, 0);
    wr(5'd25, ctrl_word(1, 0, 3'b101));
    rd(5'd25, v); chk(v == 0, "R7 disable refused", v, 0);
    rd(5'd19, prev);
    repeat (40) @(negedge clk);
    rd(5'd19, v); chk(v > prev, "R7 still counting", v, prev + 10);

    // R8 / R9 overflow timing per prescale
    for (int k = 0; k < 5; k++) begin
      p = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 2 : (k == 3) ? 3 : 7;
      do_reset(); open_flag();
      wr(5'd25, ctrl_word(0, p, 3'b101));
      kick_seq();
      measure(0, n);
      chk(n >= 256 * BASE_DIV * div_of(p) - 2 && n <= 256 * BASE_DIV * div_of(p) + 2,
          "R8 overflow distance", n, 256 * BASE_DIV * div_of(p));
      if (k == 0) begin
        n = 1;
        while (wd_reset) begin @(negedge clk); if (wd_reset) n++; end
        chk(n == RST_LEN, "R9 overflow pulse width", n, RST_LEN);
        rd(5'd19, v); chk(v <= 1, "R9 restart from zero", v, 0);
      end
    end

    // R10 wake instead of reset
    do_reset(); open_flag();
    wake_en = 1'b1;
    kick_seq();
    measure(1, n);
    chk(n >= 256 * BASE_DIV - 2 && n <= 256 * BASE_DIV + 2, "R10 wake distance", n, 256 * BASE_DIV);
    chk(!wd_reset, "R10 no reset", int'(wd_reset), 0);
    @(negedge clk);
    chk(!wd_wake, "R10 one cycle", int'(wd_wake), 0);
    rd(5'd19, v); chk(v <= 1, "R10 counter wrapped", v, 0);
    wake_en = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule